// File: doc/BRIEF.md
# Programmable Three-Input Logic Cell Chain

This block holds a row of identical programmable logic cells. There are two cells by default. Each cell takes three single-bit inputs, called A, B and C, and drives one output. A three-bit function code selects what the cell computes: a forced low, a three-input AND, OR or XOR, a registered flip-flop, or a straight copy of one input. Every input has its own inversion bit, which conditions that input before it enters the function logic. A separate inversion bit complements the result after the function is selected.

Each cell after the first has a chain bit. When the chain bit is set, the cell takes the output of the previous cell as its A input and ignores its own A pin. The previous cell's output is taken after that cell's output inversion, so two cells can be combined into functions of up to five inputs.

Configuration is static, level-driven input. Each cell has one 8-bit field. All function paths are combinational except the flip-flop mode. The flip-flop is clocked by the system clock and cleared by the active-low reset.

Top module: `lgc_chain`

## Requirements
- R1: While reset is low, and after reset until the first enabled capture, the flip-flop of every cell holds 0. In flip-flop mode the output then equals the output-inversion bit.
- R2: Function code 3'b000 (off) forces the cell result to 0 before output inversion.
- R3: Function code 3'b001 gives the AND of the three conditioned inputs.
- R4: Function code 3'b010 gives the OR of the three conditioned inputs.
- R5: Function code 3'b011 gives the XOR of the three conditioned inputs.
- R6: Function codes 3'b101, 3'b110 and 3'b111 copy the conditioned A, B and C input respectively.
- R7: Configuration bits 3, 4 and 5 invert inputs A, B and C respectively before the function logic.
- R8: Configuration bit 6 inverts the cell output after the function is selected, and this applies in every mode.
- R9: In flip-flop mode (code 3'b100), each rising clock edge does one of three things. If conditioned C is 1, the register is cleared. Otherwise, if conditioned B is 1, it loads conditioned A. Otherwise it holds its value.
- R10: When a cell is not in flip-flop mode, its register holds its value and shows it again when flip-flop mode is selected.
- R11: For every cell after the first, setting configuration bit 7 makes that cell's A input the previous cell's output, taken after output inversion. The cell's own A inversion still applies to it.
- R12: With configuration bit 7 clear, a cell uses its own A pin. Bit 7 of the first cell has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the flip-flop mode |
| rst_n | input | 1 | Asynchronous active-low reset of the cell registers |
| pin_a | input | N_CELLS | Raw A input for each cell (bit i belongs to cell i) |
| pin_b | input | N_CELLS | Raw B input for each cell |
| pin_c | input | N_CELLS | Raw C input for each cell |
| cell_cfg | input | 8*N_CELLS | Per-cell configuration: bits [2:0] function code, 3/4/5 invert A/B/C, 6 invert output, 7 chain; byte i belongs to cell i |
| cell_y | output | N_CELLS | Output of each cell |

## Verification
The hardest state to reach from the ports is a flip-flop that still holds a value captured earlier while its cell has been running a combinational function. That case shows only when flip-flop mode is selected again. The bench loads a 1 into the register, switches the cell to AND while driving inputs that would load or clear the register if it were still active, clocks several times, and returns to flip-flop mode with the enable low. The chain path also needs care. The bench drives the second cell's own A pin opposite to the first cell's output, so a wrong source selection or a missing output inversion on the chained path shows at the second cell's output.

// File: rtl/lgc_pkg.sv
package lgc_pkg;

    typedef enum logic [2:0] {
        FN_OFF  = 3'b000,
        FN_AND  = 3'b001,
        FN_OR   = 3'b010,
        FN_XOR  = 3'b011,
        FN_REG  = 3'b100,
        FN_PASA = 3'b101,
        FN_PASB = 3'b110,
        FN_PASC = 3'b111
    } cell_fn_e;

    typedef struct packed {
        logic     chain;
        logic     inv_y;
        logic     inv_c;
        logic     inv_b;
        logic     inv_a;
        cell_fn_e fn;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    typedef struct packed {
        logic ff;
    } cell_state_t;

endpackage

// File: rtl/lgc_cell.sv
module lgc_cell
    import lgc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cell_cfg_t cfg,
    input  logic      a_in,
    input  logic      b_in,
    input  logic      c_in,
    output logic      y_out
);

    cell_state_t st_d, st_q;
    logic a_e, b_e, c_e;
    logic fn_res;

    always_comb begin
        a_e  = a_in ^ cfg.inv_a;
        b_e  = b_in ^ cfg.inv_b;
        c_e  = c_in ^ cfg.inv_c;
        st_d = st_q;
        case (cfg.fn)
            FN_OFF:  fn_res = 1'b0;
            FN_AND:  fn_res = a_e & b_e & c_e;
            FN_OR:   fn_res = a_e | b_e | c_e;
            FN_XOR:  fn_res = a_e ^ b_e ^ c_e;
            FN_REG:  fn_res = st_q.ff;
            FN_PASA: fn_res = a_e;
            FN_PASB: fn_res = b_e;
            FN_PASC: fn_res = c_e;
            default: fn_res = 1'b0;
        endcase
        if (cfg.fn == FN_REG) begin
            if (c_e)
                st_d.ff = 1'b0;
            else if (b_e)
                st_d.ff = a_e;
        end
        y_out = fn_res ^ cfg.inv_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R9: a clear wins over enable
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fn == FN_REG && (c_in ^ cfg.inv_c)) |=> (st_q.ff == 1'b0));

    // R9: enabled capture loads A
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fn == FN_REG && !(c_in ^ cfg.inv_c) && (b_in ^ cfg.inv_b))
        |=> (st_q.ff == $past(a_in ^ cfg.inv_a)));

    // R9: no enable, no clear -> hold
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fn == FN_REG && !(c_in ^ cfg.inv_c) && !(b_in ^ cfg.inv_b))
        |=> $stable(st_q.ff));

    // R10: register frozen outside flip-flop mode
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fn != FN_REG) |=> $stable(st_q.ff));

    // R2/R8: off mode output equals output inversion bit
    a_r2_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fn == FN_OFF) |-> (y_out == cfg.inv_y));

endmodule

// File: rtl/lgc_chain.sv
module lgc_chain
    import lgc_pkg::*;
#(
    parameter int N_CELLS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CELLS-1:0]         pin_a,
    input  logic [N_CELLS-1:0]         pin_b,
    input  logic [N_CELLS-1:0]         pin_c,
    input  logic [N_CELLS*CFG_W-1:0]   cell_cfg,
    output logic [N_CELLS-1:0]         cell_y
);

    logic [N_CELLS-1:0] a_src;
    logic [N_CELLS-1:0] y_int;

    assign cell_y = y_int;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        cell_cfg_t cfg_i;
        assign cfg_i = cell_cfg_t'(cell_cfg[i*CFG_W +: CFG_W]);

        if (i == 0) begin : g_head
            assign a_src[i] = pin_a[i];
        end else begin : g_link
            assign a_src[i] = cfg_i.chain ? y_int[i-1] : pin_a[i];

            // R11: chained A follows previous output
            a_r11_chain: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_i.chain |-> (a_src[i] == cell_y[i-1]));
            // R12: unchained A follows own pin
            a_r12_own: assert property (@(posedge clk) disable iff (!rst_n)
                !cfg_i.chain |-> (a_src[i] == pin_a[i]));
        end

        lgc_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (cfg_i),
            .a_in  (a_src[i]),
            .b_in  (pin_b[i]),
            .c_in  (pin_c[i]),
            .y_out (y_int[i])
        );
    end

endmodule

// File: tb/lgc_chain_test.sv
module lgc_chain_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_a = '0, pin_b = '0, pin_c = '0;
    logic [15:0] cfg = '0;
    logic [1:0] y;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lgc_chain #(.N_CELLS(2)) uut (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .pin_c(pin_c), .cell_cfg(cfg), .cell_y(y)
    );

    // {cfg1, cfg0, a, b, c, expected y}
    localparam int NV = 17;
    localparam logic [29:0] VEC [NV] = '{
        {8'h00, 8'h00, 2'b11, 2'b11, 2'b11, 2'b00}, // R2
        {8'h40, 8'h40, 2'b00, 2'b00, 2'b00, 2'b11}, // R8
        {8'h01, 8'h01, 2'b01, 2'b11, 2'b11, 2'b01}, // R3
        {8'h00, 8'h01, 2'b01, 2'b00, 2'b01, 2'b00}, // R3
        {8'h02, 8'h02, 2'b00, 2'b00, 2'b01, 2'b01}, // R4
        {8'h03, 8'h03, 2'b11, 2'b11, 2'b01, 2'b01}, // R5
        {8'h03, 8'h03, 2'b11, 2'b10, 2'b10, 2'b11}, // R5
        {8'h06, 8'h05, 2'b01, 2'b10, 2'b00, 2'b11}, // R6
        {8'h07, 8'h07, 2'b01, 2'b01, 2'b10, 2'b10}, // R6
        {8'h09, 8'h39, 2'b00, 2'b10, 2'b10, 2'b11}, // R7
        {8'h16, 8'h0D, 2'b01, 2'b00, 2'b00, 2'b10}, // R7
        {8'h42, 8'h41, 2'b01, 2'b01, 2'b01, 2'b10}, // R8
        {8'h85, 8'h05, 2'b01, 2'b00, 2'b00, 2'b11}, // R11
        {8'h85, 8'h45, 2'b11, 2'b00, 2'b00, 2'b00}, // R11
        {8'h8D, 8'h05, 2'b01, 2'b00, 2'b00, 2'b01}, // R11
        {8'h05, 8'h05, 2'b01, 2'b00, 2'b00, 2'b01}, // R12
        {8'h00, 8'h85, 2'b01, 2'b00, 2'b00, 2'b01}  // R12
    };
    localparam string VTAG [NV] = '{"R2", "R8", "R3", "R3", "R4", "R5", "R5",
        "R6", "R6", "R7", "R7", "R8", "R11", "R11", "R11", "R12", "R12"};

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, cell0 in flip-flop mode with enable driven high
        cfg = {8'h00, 8'h04};
        pin_a = 2'b01; pin_b = 2'b01;
        repeat (2) @(negedge clk);
        check("R1", y, 2'b00);
        pin_a = 2'b00; pin_b = 2'b00;
        rst_n = 1'b1;
        tick();
        check("R1", y, 2'b00);

        for (int i = 0; i < NV; i++) begin
            {cfg[15:8], cfg[7:0], pin_a, pin_b, pin_c} = VEC[i][29:2];
            #1;
            check(VTAG[i], y, VEC[i][1:0]);
            @(negedge clk);
        end

        // R9: flip-flop load, hold, clear priority
        cfg = {8'h00, 8'h04};
        pin_a = 2'b01; pin_b = 2'b01; pin_c = 2'b00;
        #1 check("R9", y, 2'b00);   // nothing captured yet
        tick();
        check("R9", y, 2'b01);
        pin_a = 2'b00; pin_b = 2'b00;
        tick();
        check("R9", y, 2'b01);      // hold
        pin_a = 2'b01; pin_b = 2'b01; pin_c = 2'b01;
        tick();
        check("R9", y, 2'b00);      // clear beats enable
        pin_c = 2'b00;
        tick();
        check("R9", y, 2'b01);
        // R8 on flip-flop output
        cfg = {8'h00, 8'h44};
        #1 check("R8", y, 2'b00);

        // R10: switch away, drive clear and load patterns, come back
        cfg = {8'h00, 8'h01};
        pin_a = 2'b00; pin_b = 2'b01; pin_c = 2'b01;
        tick();
        tick();
        pin_c = 2'b00;
        tick();
        check("R10", y, 2'b00);     // AND of 0,1,0
        cfg = {8'h00, 8'h04};
        pin_b = 2'b00;
        #1 check("R10", y, 2'b01);
        tick();
        check("R10", y, 2'b01);

        // R9 with input inversion: inverted B enables, inverted A is D
        cfg = {8'h00, 8'h1C};
        pin_a = 2'b01; pin_b = 2'b00; pin_c = 2'b00;
        tick();
        check("R9", y, 2'b00);

        // R11: chained cell1 flip-flop captures cell0 output
        cfg = {8'h84, 8'h05};
        pin_a = 2'b01; pin_b = 2'b10; pin_c = 2'b00;
        tick();
        check("R11", y, 2'b11);

        // R1: asynchronous reset mid-run
        rst_n = 1'b0;
        #1 check("R1", y, 2'b01);
        tick();
        rst_n = 1'b1;
        cfg = {8'h04, 8'h04};
        pin_b = 2'b00;
        #1 check("R1", y, 2'b00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule